// File: doc/BRIEF.md
# Masked Integer Rank-k Update Unit

This block takes one request per cycle and returns an updated 4×4 matrix of 32-bit signed integers one cycle later. Each result element is a masked dot product between one 32-bit row of the X operand and one 32-bit row of the Y operand. Both operands are 128 bits wide. The row packing depends on the element format: two signed 16-bit values, four 8-bit values (X signed, Y unsigned), or eight signed 4-bit values. The request can add the incoming accumulator matrix to each dot product.

Three masks control which terms are used. A row mask selects rows of X. A column mask selects rows of Y, which are the columns of the transposed operand. A product mask selects individual inner-index terms. A term that is masked out contributes zero.

A saturating mode clamps each final sum to the signed 32-bit range. Saturation is honoured only for the 16-bit forms and for the accumulating 8-bit form. If a request asks for saturation in any other form, the unit raises an illegal flag and computes that request with wrap-around arithmetic.

Top module: `rku_unit`

## Requirements
- R1: `in_ready` is always high. A request presented with `in_valid` produces `res_valid` high on the next cycle only. A cycle without `in_valid` gives `res_valid` low on the following cycle.
- R2: Format code 0 (16-bit): row i of each operand is bits [32i+31:32i], holding signed values with k=0 in the low half. Element (i,j) of the result sits at bits [32(4i+j)+31:32(4i+j)] and equals the sum over k of X[i][k]·Y[j][k].
- R3: Format code 1 (8-bit): each row holds four bytes with k=0 in the least significant byte. X bytes are signed and Y bytes are unsigned.
- R4: Format code 2 (4-bit): each row holds eight signed nibbles with k=0 in the least significant nibble.
- R5: With `in_accum` high, the incoming accumulator element at the same position is added to the sum. Without saturation the result wraps modulo 2^32.
- R6: For the 16-bit format with `in_sat` high, the exact total of products and accumulator is clamped to 0x7FFFFFFF or 0x80000000. This applies whether or not the request accumulates.
- R7: For the 8-bit format, saturation applies only when `in_accum` is high. A saturating non-accumulating 8-bit request sets `res_illegal` and is computed modulo.
- R8: For the 4-bit format, any request with `in_sat` high sets `res_illegal` and the result wraps.
- R9: Row mask bit i and column mask bit j both gate element (i,j). If either is clear, the element is 0 when not accumulating and equals the accumulator element when accumulating.
- R10: Product mask bit k gates term k. Only bits [1:0] are used for the 16-bit format, [3:0] for 8-bit and [7:0] for 4-bit; the higher bits have no effect.
- R11: Format code 3 sets `res_illegal` and gives an all-zero result, even when accumulating.
- R12: After reset, `res_valid` and `res_illegal` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted (always high) |
| in_fmt | input | 2 | Element format: 0 16-bit, 1 8-bit, 2 4-bit, 3 invalid |
| in_accum | input | 1 | Add the accumulator matrix |
| in_sat | input | 1 | Request saturating arithmetic |
| in_xmask | input | 4 | Row enables for X |
| in_ymask | input | 4 | Row enables for Y |
| in_pmask | input | 8 | Inner-index term enables |
| in_x | input | 128 | X operand |
| in_y | input | 128 | Y operand |
| in_acc | input | 512 | Accumulator matrix |
| res_valid | output | 1 | Result present |
| res_illegal | output | 1 | Request used a disallowed format or saturation combination |
| res_data | output | 512 | Result matrix |

## Verification
The assertions assume that the request fields are stable and known whenever `in_valid` is high, and that a result is consumed in the cycle it appears, since nothing can hold it back. The bench drives every request at the falling clock edge with fully defined fields. It holds each request for exactly one rising edge and then drops `in_valid` for a cycle, so each result is seen in isolation. The saturation assertions also assume that `SUM_W` is wide enough for the exact total. The parameter check enforces this, and the bench keeps the default width.

// File: rtl/rku_pkg.sv
package rku_pkg;
   typedef enum logic [1:0] {
      FMT_I16 = 2'd0,
      FMT_I8  = 2'd1,
      FMT_I4  = 2'd2,
      FMT_BAD = 2'd3
   } rku_fmt_e;

   localparam int LANE_W = 32;
   localparam int MAX_K  = 8;
endpackage

// File: rtl/rku_dot.sv
module rku_dot
   import rku_pkg::*;
#(
   parameter int SUM_W = 36
) (
   input  rku_fmt_e                 fmt,
   input  logic [LANE_W-1:0]        xrow,
   input  logic [LANE_W-1:0]        yrow,
   input  logic [MAX_K-1:0]         pmask,
   input  logic                     en,
   output logic signed [SUM_W-1:0]  sum
);
   logic signed [15:0]      xa, ya;
   logic signed [31:0]      p16;
   logic signed [7:0]       xb;
   logic signed [8:0]       yb;
   logic signed [16:0]      p8;
   logic signed [3:0]       xc, yc;
   logic signed [7:0]       p4;
   logic signed [SUM_W-1:0] s16, s8, s4;

   always_comb begin
      xa = '0; ya = '0; p16 = '0;
      xb = '0; yb = '0; p8 = '0;
      xc = '0; yc = '0; p4 = '0;
      s16 = '0; s8 = '0; s4 = '0;
      for (int k = 0; k < 2; k++) begin
         xa  = xrow[16*k +: 16];
         ya  = yrow[16*k +: 16];
         p16 = xa * ya;
         if (pmask[k]) s16 = s16 + SUM_W'(p16);
      end
      for (int k = 0; k < 4; k++) begin
         xb = xrow[8*k +: 8];
         yb = {1'b0, yrow[8*k +: 8]};
         p8 = xb * yb;
         if (pmask[k]) s8 = s8 + SUM_W'(p8);
      end
      for (int k = 0; k < 8; k++) begin
         xc = xrow[4*k +: 4];
         yc = yrow[4*k +: 4];
         p4 = xc * yc;
         if (pmask[k]) s4 = s4 + SUM_W'(p4);
      end
   end

   always_comb begin
      sum = '0;
      if (en) begin
         unique case (fmt)
            FMT_I16: sum = s16;
            FMT_I8:  sum = s8;
            FMT_I4:  sum = s4;
            default: sum = '0;
         endcase
      end
   end
endmodule

// File: rtl/rku_sat.sv
module rku_sat #(
   parameter int SUM_W = 36,
   parameter int OUT_W = 32
) (
   input  logic signed [SUM_W-1:0] total,
   input  logic                    sat_en,
   output logic [OUT_W-1:0]        q
);
   localparam logic signed [SUM_W-1:0] HI = {{(SUM_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
   localparam logic signed [SUM_W-1:0] LO = {{(SUM_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

   always_comb begin
      if (sat_en && (total > HI))      q = HI[OUT_W-1:0];
      else if (sat_en && (total < LO)) q = LO[OUT_W-1:0];
      else                             q = total[OUT_W-1:0];
   end
endmodule

// File: rtl/rku_unit.sv
module rku_unit
   import rku_pkg::*;
#(
   parameter int ACC_W = 32,
   parameter int DIM   = 4,
   parameter int SUM_W = 36
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   output logic                       in_ready,
   input  logic [1:0]                 in_fmt,
   input  logic                       in_accum,
   input  logic                       in_sat,
   input  logic [DIM-1:0]             in_xmask,
   input  logic [DIM-1:0]             in_ymask,
   input  logic [7:0]                 in_pmask,
   input  logic [DIM*32-1:0]          in_x,
   input  logic [DIM*32-1:0]          in_y,
   input  logic [DIM*DIM*ACC_W-1:0]   in_acc,
   output logic                       res_valid,
   output logic                       res_illegal,
   output logic [DIM*DIM*ACC_W-1:0]   res_data
);
   localparam int MAT_W = DIM * DIM * ACC_W;
   localparam logic signed [SUM_W-1:0] SAT_HI = {{(SUM_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
   localparam logic signed [SUM_W-1:0] SAT_LO = {{(SUM_W-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}};

   if (ACC_W != LANE_W) begin : g_bad_acc
      $error("rku_unit: ACC_W must equal the 32-bit lane width");
   end
   if (SUM_W < ACC_W + 4) begin : g_bad_sum
      $error("rku_unit: SUM_W too narrow for the exact total");
   end
   if (DIM < 1) begin : g_bad_dim
      $error("rku_unit: DIM must be positive");
   end

   rku_fmt_e fmt;
   logic     fire, sat_bad, illegal, eff_sat, use_acc;
   logic [MAT_W-1:0] next_data;

   assign fmt      = rku_fmt_e'(in_fmt);
   assign in_ready = 1'b1;
   assign fire     = in_valid && in_ready;
   assign sat_bad  = in_sat && (((fmt == FMT_I8) && !in_accum) || (fmt == FMT_I4));
   assign illegal  = (fmt == FMT_BAD) || sat_bad;
   assign eff_sat  = in_sat && !illegal;
   assign use_acc  = in_accum && (fmt != FMT_BAD);

   for (genvar i = 0; i < DIM; i++) begin : g_row
      for (genvar j = 0; j < DIM; j++) begin : g_col
         localparam int IDX = i*DIM + j;
         logic signed [SUM_W-1:0] dot, total;
         logic [ACC_W-1:0]        q;

         rku_dot #(.SUM_W(SUM_W)) i_dot (
            .fmt   (fmt),
            .xrow  (in_x[32*i +: 32]),
            .yrow  (in_y[32*j +: 32]),
            .pmask (in_pmask),
            .en    (in_xmask[i] && in_ymask[j]),
            .sum   (dot)
         );

         assign total = dot + (use_acc ? SUM_W'($signed(in_acc[ACC_W*IDX +: ACC_W])) : '0);

         rku_sat #(.SUM_W(SUM_W), .OUT_W(ACC_W)) i_sat (
            .total  (total),
            .sat_en (eff_sat),
            .q      (q)
         );

         assign next_data[ACC_W*IDX +: ACC_W] = q;

         // R6: a saturating total above the range lands on the top value
         a_r6_clamp_hi: assert property (@(posedge clk) disable iff (!rst_n)
            (fire && eff_sat && (total > SAT_HI)) |=> (res_data[ACC_W*IDX +: ACC_W] == SAT_HI[ACC_W-1:0]));
         // R6: a saturating total below the range lands on the bottom value
         a_r6_clamp_lo: assert property (@(posedge clk) disable iff (!rst_n)
            (fire && eff_sat && (total < SAT_LO)) |=> (res_data[ACC_W*IDX +: ACC_W] == SAT_LO[ACC_W-1:0]));
         // R9: masked element without accumulation reads zero
         a_r9_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (fire && !in_accum && !(in_xmask[i] && in_ymask[j])) |=> (res_data[ACC_W*IDX +: ACC_W] == '0));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid   <= 1'b0;
         res_illegal <= 1'b0;
         res_data    <= '0;
      end else begin
         res_valid <= fire;
         if (fire) begin
            res_illegal <= illegal;
            res_data    <= (fmt == FMT_BAD) ? '0 : next_data;
         end
      end
   end

   a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> res_valid);
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !res_valid);
   a_r8_nibble_sat_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (in_fmt == 2'd2) && in_sat) |=> res_illegal);
   a_r11_bad_fmt_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (in_fmt == 2'd3)) |=> (res_illegal && (res_data == '0)));
endmodule

// File: tb/test_rku_unit.sv
`timescale 1ns/1ps
module test_rku_unit;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [1:0]   in_fmt = '0;
   logic         in_accum = 1'b0;
   logic         in_sat = 1'b0;
   logic [3:0]   in_xmask = '0;
   logic [3:0]   in_ymask = '0;
   logic [7:0]   in_pmask = '0;
   logic [127:0] in_x = '0;
   logic [127:0] in_y = '0;
   logic [511:0] in_acc = '0;
   logic         res_valid;
   logic         res_illegal;
   logic [511:0] res_data;

   int  n_checks = 0;
   int  n_errors = 0;
   bit  done = 1'b0;

   always #2.5 clk = ~clk;

   rku_unit i_rku_unit (
      .clk, .rst_n, .in_valid, .in_ready, .in_fmt, .in_accum, .in_sat,
      .in_xmask, .in_ymask, .in_pmask, .in_x, .in_y, .in_acc,
      .res_valid, .res_illegal, .res_data
   );

   task automatic check(string req, logic [511:0] got, logic [511:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   function automatic logic [511:0] model(int fmt, bit acc, bit sat, logic [3:0] xm,
                                          logic [3:0] ym, logic [7:0] pm,
                                          logic [127:0] x, logic [127:0] y,
                                          logic [511:0] a, output bit ill);
      logic [511:0] r = '0;
      bit legal = !((fmt == 3) || (sat && ((fmt == 1 && !acc) || fmt == 2)));
      ill = !legal;
      if (fmt == 3) return '0;
      for (int i = 0; i < 4; i++) begin
         for (int j = 0; j < 4; j++) begin
            logic signed [63:0] s = 0;
            if (xm[i] && ym[j]) begin
               if (fmt == 0)
                  for (int k = 0; k < 2; k++)
                     if (pm[k]) s += 64'($signed(x[32*i+16*k +: 16])) * 64'($signed(y[32*j+16*k +: 16]));
               if (fmt == 1)
                  for (int k = 0; k < 4; k++)
                     if (pm[k]) s += 64'($signed(x[32*i+8*k +: 8])) * 64'({1'b0, y[32*j+8*k +: 8]});
               if (fmt == 2)
                  for (int k = 0; k < 8; k++)
                     if (pm[k]) s += 64'($signed(x[32*i+4*k +: 4])) * 64'($signed(y[32*j+4*k +: 4]));
            end
            if (acc) s += 64'($signed(a[32*(4*i+j) +: 32]));
            if (sat && legal) begin
               if (s > 64'sh7FFF_FFFF) s = 64'sh7FFF_FFFF;
               if (s < -64'sh8000_0000) s = -64'sh8000_0000;
            end
            r[32*(4*i+j) +: 32] = s[31:0];
         end
      end
      return r;
   endfunction

   task automatic apply(string req, int fmt, bit acc, bit sat, logic [3:0] xm, logic [3:0] ym,
                        logic [7:0] pm, logic [127:0] x, logic [127:0] y, logic [511:0] a);
      logic [511:0] exp;
      bit ill;
      exp = model(fmt, acc, sat, xm, ym, pm, x, y, a, ill);
      @(negedge clk);
      in_valid = 1'b1; in_fmt = 2'(fmt); in_accum = acc; in_sat = sat;
      in_xmask = xm; in_ymask = ym; in_pmask = pm; in_x = x; in_y = y; in_acc = a;
      @(negedge clk);
      in_valid = 1'b0;
      check({req, " R1 valid"}, 512'(res_valid), 512'(1));
      check({req, " data"}, res_data, exp);
      check({req, " illegal"}, 512'(res_illegal), 512'(ill));
      @(negedge clk);
      check({req, " R1 idle"}, 512'(res_valid), 512'(0));
   endtask

   localparam logic [127:0] XA = 128'h1234_F00D_8001_7FFE_0003_FFFD_ABCD_5555;
   localparam logic [127:0] YA = 128'h7FFF_0002_FFFF_8000_00FF_0101_3C3C_E1E1;
   localparam logic [511:0] AA = {4{128'h7FFF_FFF0_8000_0010_0000_1234_FFFF_FFFF}};

   task automatic t_reset();
      check("R12 reset valid", 512'(res_valid), 512'(0));
      check("R12 reset illegal", 512'(res_illegal), 512'(0));
      check("R1 ready", 512'(in_ready), 512'(1));
   endtask

   task automatic t_i16();
      apply("R2 16-bit plain", 0, 0, 0, 4'hF, 4'hF, 8'hFF, XA, YA, '0);
      apply("R5 16-bit accum", 0, 1, 0, 4'hF, 4'hF, 8'hFF, XA, YA, AA);
      apply("R5 16-bit wrap", 0, 0, 0, 4'hF, 4'hF, 8'hFF, {8{16'h8000}}, {8{16'h8000}}, '0);
      apply("R6 16-bit sat high", 0, 0, 1, 4'hF, 4'hF, 8'hFF, {8{16'h8000}}, {8{16'h8000}}, '0);
      apply("R6 16-bit sat low", 0, 1, 1, 4'hF, 4'hF, 8'hFF, {8{16'h8000}}, {8{16'h7FFF}}, {16{32'h8000_0000}});
   endtask

   task automatic t_i8();
      apply("R3 8-bit mixed sign", 1, 0, 0, 4'hF, 4'hF, 8'hFF, {16{8'h80}}, {16{8'hFF}}, '0);
      apply("R3 8-bit pattern", 1, 0, 0, 4'hF, 4'hF, 8'hFF, XA, YA, '0);
      apply("R7 8-bit accum sat", 1, 1, 1, 4'hF, 4'hF, 8'hFF, {16{8'h80}}, {16{8'hFF}}, {16{32'h8000_0000}});
      apply("R7 8-bit plain sat illegal", 1, 0, 1, 4'hF, 4'hF, 8'hFF, XA, YA, '0);
   endtask

   task automatic t_i4();
      apply("R4 4-bit signed", 2, 0, 0, 4'hF, 4'hF, 8'hFF, {32{4'h8}}, {32{4'h7}}, '0);
      apply("R4 4-bit pattern", 2, 0, 0, 4'hF, 4'hF, 8'hFF, XA, YA, '0);
      apply("R8 4-bit sat wraps", 2, 1, 1, 4'hF, 4'hF, 8'hFF, {32{4'h7}}, {32{4'h7}}, {16{32'h7FFF_FFFF}});
   endtask

   task automatic t_masks();
      apply("R9 masks plain", 0, 0, 0, 4'b0101, 4'b1010, 8'hFF, XA, YA, '0);
      apply("R9 masks accum", 1, 1, 0, 4'b1100, 4'b0110, 8'hFF, XA, YA, AA);
      apply("R10 pmask 16-bit upper ignored", 0, 0, 0, 4'hF, 4'hF, 8'hFD, XA, YA, '0);
      apply("R10 pmask 8-bit", 1, 0, 0, 4'hF, 4'hF, 8'hF6, XA, YA, '0);
      apply("R10 pmask 4-bit", 2, 0, 0, 4'hF, 4'hF, 8'h5A, XA, YA, '0);
   endtask

   task automatic t_bad();
      apply("R11 bad format", 3, 1, 0, 4'hF, 4'hF, 8'hFF, XA, YA, AA);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_i16();
      t_i8();
      t_i4();
      t_masks();
      t_bad();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #20000;
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule